// File: doc/BRIEF.md
# Grouped GPIO Edge Interrupt Controller

This block watches thirteen asynchronous pin inputs. It synchronizes each one and compares its level from cycle to cycle. When a pin shows the transition that its two-bit mode field asks for, the block records the event as a sticky pending bit.

The pending bits are split unevenly into two byte-wide groups. Pins 0 to 6 form the low group and pins 7 to 12 form the high group. Each group has a status register and a mask register on a small byte-wide register port.

A single interrupt line is high while any pending bit is set and not blocked by its mask bit. Software finds out which pins fired by reading the status registers. It acknowledges a pin by writing a 1 to that pin's status bit.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: Each pin passes through a two-flop synchronizer and an edge stage. A qualifying change on `pin_in` that is driven before clock edge 1 is visible in its status bit after clock edge 3, and not after clock edge 2.
- R2: Pin p takes its edge mode from `edge_mode[2p+1:2p]`. The encodings are 0 = no detection, 1 = falling edge only, 2 = rising edge only, 3 = both edges.
- R3: Status address 0x4E0B holds pins 0..6 in bits 6:0. Status address 0x4E0C holds pins 7..12 in bits 5:0, with pin 7 at bit 0. A detected edge sets its bit, and the bit stays set until it is cleared.
- R4: Mask address 0x4E19 holds pins 0..6 in bits 6:0, and mask address 0x4E1A holds pins 7..12 in bits 5:0. A write stores the byte, and the value reads back.
- R5: A write of 1 to a status bit clears it. A write of 0 to a status bit leaves it unchanged.
- R6: If an edge is detected in the same cycle that a clear hits its bit, the bit stays set.
- R7: `irq` is high exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 does not stop the status bit from latching.
- R8: Register bits above a group's width, and every address other than the four listed, read as 0 and ignore writes.
- R9: After reset, all mask bits are 1, all status bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 13 | Raw pin levels, asynchronous |
| edge_mode | input | 26 | Two-bit detection mode for each pin |
| reg_addr | input | 16 | Register address, used for both read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Summary interrupt |

## Verification
The bench lands a clear on the exact cycle in which a new edge is detected. A design that lets the clear win would lose that event, and the status byte would read 0.

It drives edges into fully masked pins and expects them to latch with `irq` still low. A design that gated detection with the mask would show the bit missing once the pin is unmasked.

It writes 1s into the unused upper bits and to neighbouring addresses. A design with a decode or width slip would read those bits back as nonzero or would corrupt a real register.

Sampling one cycle early at the pin-change boundary and testing mode 0 catch a synchronizer of the wrong depth and a polarity decode that is swapped.

// File: rtl/gei_pkg.sv
package gei_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_RISE = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_mode_e;

   function automatic logic edge_hit(edge_mode_e mode, logic was, logic now);
      case (mode)
         EDGE_FALL: edge_hit = was & ~now;
         EDGE_RISE: edge_hit = ~was & now;
         EDGE_BOTH: edge_hit = was ^ now;
         default:   edge_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/gei_edge_det.sv
module gei_edge_det
   import gei_pkg::*;
#(
   parameter int NUM_PINS    = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_in,
   input  logic [2*NUM_PINS-1:0] edge_mode,
   output logic [NUM_PINS-1:0]   det
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
         end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in[p]};
            last_q <= sync_q[SYNC_STAGES-1];
         end
      end

      assign det[p] = edge_hit(edge_mode_e'(edge_mode[2*p +: 2]),
                               last_q, sync_q[SYNC_STAGES-1]);
   end

endmodule

// File: rtl/gei_group.sv
module gei_group #(
   parameter int              WIDTH     = 7,
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
   parameter logic [ADDR_W-1:0] MASK_ADDR = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  det,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              irq,
   output logic              rd_hit,
   output logic [7:0]        rd_byte
);

   if (WIDTH < 1 || WIDTH > 8) begin : g_bad_width
      $error("gei_group: WIDTH must lie in 1..8");
   end

   logic [WIDTH-1:0] stat_q;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] clr;
   logic             stat_sel;
   logic             mask_sel;
   logic             stat_we;
   logic             mask_we;
   logic             wdata_unused;

   assign stat_sel     = (addr == STAT_ADDR);
   assign mask_sel     = (addr == MASK_ADDR);
   assign stat_we      = wr && stat_sel;
   assign mask_we      = wr && mask_sel;
   assign clr          = stat_we ? wdata[WIDTH-1:0] : '0;
   assign wdata_unused = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= (stat_q & ~clr) | det;
         if (mask_we) mask_q <= wdata[WIDTH-1:0];
      end
   end

   assign irq     = |(stat_q & ~mask_q);
   assign rd_hit  = stat_sel || mask_sel;
   assign rd_byte = stat_sel ? 8'(stat_q) : (mask_sel ? 8'(mask_q) : 8'h00);

   for (genvar b = 0; b < WIDTH; b++) begin : g_chk
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[b] && !clr[b]) |=> stat_q[b]);
      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         det[b] |=> stat_q[b]);
      assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_q[b] && !det[b]) |=> !stat_q[b]);
   end

   assert_mask_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask_q));
   assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq);

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_R9: assert (stat_q == '0 && mask_q == '1 && !irq);
      end
   end

endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl #(
   parameter int ADDR_W      = 16,
   parameter int NUM_PINS    = 13,
   parameter int LOW_PINS    = 7,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B,
   parameter logic [ADDR_W-1:0] MASK_BASE = 16'h4E19
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_in,
   input  logic [2*NUM_PINS-1:0] edge_mode,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_wr,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   output logic                  irq
);

   localparam int NUM_GROUPS = 2;
   localparam int HIGH_PINS  = NUM_PINS - LOW_PINS;

   if (LOW_PINS < 1 || LOW_PINS > 8 || HIGH_PINS < 1 || HIGH_PINS > 8) begin : g_bad_split
      $error("gpio_edge_irq_ctrl: each group must hold 1..8 pins");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_edge_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0]   det;
   logic [NUM_GROUPS-1:0] grp_irq;
   logic [NUM_GROUPS-1:0] grp_hit;
   logic [7:0]            grp_byte [NUM_GROUPS];

   gei_edge_det #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) edge_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .edge_mode (edge_mode),
      .det       (det)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam int W   = (g == 0) ? LOW_PINS : HIGH_PINS;
      localparam int LSB = (g == 0) ? 0 : LOW_PINS;
      localparam logic [ADDR_W-1:0] SA = STAT_BASE + ADDR_W'(g);
      localparam logic [ADDR_W-1:0] MA = MASK_BASE + ADDR_W'(g);

      gei_group #(
         .WIDTH     (W),
         .ADDR_W    (ADDR_W),
         .STAT_ADDR (SA),
         .MASK_ADDR (MA)
      ) grp_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .det     (det[LSB +: W]),
         .wr      (reg_wr),
         .addr    (reg_addr),
         .wdata   (reg_wdata),
         .irq     (grp_irq[g]),
         .rd_hit  (grp_hit[g]),
         .rd_byte (grp_byte[g])
      );
   end

   always_comb begin
      reg_rdata = 8'h00;
      for (int g = 0; g < NUM_GROUPS; g++) reg_rdata |= grp_byte[g];
   end

   assign irq = |grp_irq;

   assert_one_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grp_hit));

endmodule

// File: tb/gpio_edge_irq_ctrl_tb_top.sv
module gpio_edge_irq_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] pin_in = '0;
   logic [25:0] edge_mode = '0;
   logic [15:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_edge_irq_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .edge_mode (edge_mode),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   // behavioural reference: pending and mask as 13-bit words, pin history as a queue
   logic [12:0] m_stat = '0;
   logic [12:0] m_mask = '1;
   logic [12:0] hist[$] = '{13'd0, 13'd0, 13'd0};

   function automatic logic [7:0] exp_rd(logic [15:0] a);
      case (a)
         16'h4E0B: return {1'b0, m_stat[6:0]};
         16'h4E0C: return {2'b0, m_stat[12:7]};
         16'h4E19: return {1'b0, m_mask[6:0]};
         16'h4E1A: return {2'b0, m_mask[12:7]};
         default:  return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat = '0;
         m_mask = '1;
         hist = '{13'd0, 13'd0, 13'd0};
      end else begin
         logic [12:0] nowv, wasv, hit, clr;
         nowv = hist[1];
         wasv = hist[2];
         hit = '0;
         clr = '0;
         for (int p = 0; p < 13; p++) begin
            case (edge_mode[2*p +: 2])
               2'd1: hit[p] = wasv[p] && !nowv[p];
               2'd2: hit[p] = !wasv[p] && nowv[p];
               2'd3: hit[p] = wasv[p] != nowv[p];
               default: hit[p] = 1'b0;
            endcase
         end
         if (reg_wr && reg_addr == 16'h4E0B) clr[6:0]  = reg_wdata[6:0];
         if (reg_wr && reg_addr == 16'h4E0C) clr[12:7] = reg_wdata[5:0];
         if (reg_wr && reg_addr == 16'h4E19) m_mask[6:0]  = reg_wdata[6:0];
         if (reg_wr && reg_addr == 16'h4E1A) m_mask[12:7] = reg_wdata[5:0];
         m_stat = (m_stat & ~clr) | hit;
         hist.push_front(pin_in);
         void'(hist.pop_back());
      end
   end

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%02h expected=%02h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("R7 irq vs model", {7'd0, irq}, {7'd0, |(m_stat & ~m_mask)});
         case (reg_addr)
            16'h4E0B, 16'h4E0C: chk("R3 status vs model", reg_rdata, exp_rd(reg_addr));
            16'h4E19, 16'h4E1A: chk("R4 mask vs model", reg_rdata, exp_rd(reg_addr));
            default:            chk("R8 unmapped vs model", reg_rdata, exp_rd(reg_addr));
         endcase
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      reg_addr = a;
      reg_wdata = d;
      reg_wr = 1'b1;
      step(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, string tag, logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   logic [31:0] lfsr = 32'hACE1_2357;

   initial begin
      step(3);
      rd(16'h4E19, "R9 reset mask0", 8'h7F);
      rd(16'h4E1A, "R9 reset mask1", 8'h3F);
      rd(16'h4E0B, "R9 reset stat0", 8'h00);
      rd(16'h4E0C, "R9 reset stat1", 8'h00);
      chk("R9 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      step(2);

      // pin2 falling only, pin3 rising only, pin8 both edges
      edge_mode[2*2 +: 2] = 2'd1;
      edge_mode[2*3 +: 2] = 2'd2;
      edge_mode[2*8 +: 2] = 2'd3;
      step(1);
      pin_in[2] = 1'b1; pin_in[3] = 1'b1; pin_in[8] = 1'b1;
      step(2);
      rd(16'h4E0B, "R1 not yet after two edges", 8'h00);
      step(1);
      rd(16'h4E0B, "R1 R2 rising only latched", 8'h08);
      rd(16'h4E0C, "R3 pin8 at group1 bit1", 8'h02);
      chk("R7 masked pending keeps irq low", {7'd0, irq}, 8'h00);

      pin_in[2] = 1'b0; pin_in[3] = 1'b0; pin_in[8] = 1'b0;
      step(3);
      rd(16'h4E0B, "R2 falling latched, R5 sticky", 8'h0C);

      wr(16'h4E19, 8'h7B);
      rd(16'h4E19, "R4 mask readback", 8'h7B);
      chk("R7 unmasked pending raises irq", {7'd0, irq}, 8'h01);

      wr(16'h4E0B, 8'h84);
      rd(16'h4E0B, "R5 clear bit2 only, R8 bit7 ignored", 8'h08);
      chk("R7 irq drops after clear", {7'd0, irq}, 8'h00);

      // edge on pin8 lands in the same cycle as its clear
      pin_in[8] = 1'b1;
      step(2);
      wr(16'h4E0C, 8'h02);
      rd(16'h4E0C, "R6 set wins over clear", 8'h02);
      wr(16'h4E0C, 8'h02);
      rd(16'h4E0C, "R5 clear with no edge", 8'h00);

      wr(16'h4E1A, 8'hFF);
      rd(16'h4E1A, "R8 upper mask bits read 0", 8'h3F);
      wr(16'h4E0D, 8'hFF);
      rd(16'h4E0D, "R8 unmapped address reads 0", 8'h00);
      rd(16'h4E1A, "R8 unmapped write left mask1", 8'h3F);

      pin_in[0] = 1'b1;
      step(4);
      rd(16'h4E0B, "R2 mode 0 ignores pin0", 8'h08);

      for (int i = 0; i < 3000; i++) begin
         logic [15:0] alist [7];
         alist = '{16'h4E0B, 16'h4E0C, 16'h4E19, 16'h4E1A, 16'h4E0D, 16'h4E18, 16'h0000};
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[3:0] == 4'd0) edge_mode = {lfsr[25:0]};
         if (lfsr[6:4] < 3'd3) pin_in = pin_in ^ lfsr[29:17];
         reg_addr = alist[lfsr[14:8] % 7];
         reg_wr = lfsr[15] && lfsr[16];
         reg_wdata = lfsr[31:24];
         step(1);
      end
      reg_wr = 1'b0;
      step(2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule